// File: doc/BRIEF.md
# Sequential Unsigned Divider

This block divides one unsigned 32-bit operand by another. It uses a shift-and-subtract loop that retires one quotient bit per clock. A single shift register holds the partial remainder in its upper part and the growing quotient in its lower part. One subtractor per step decides whether the divisor fits into the upper part. If it fits, the difference replaces the upper part and a 1 enters at the bottom. If it does not fit, the register only shifts and a 0 enters.

A caller presents the operands and pulses the start opcode while the block is idle. It then waits for `busy_o` to fall. At that point the quotient, the remainder and a packed copy of both are stable, and they stay stable until the next accepted start. The block samples the divisor when it starts, so the caller may change the input lines as soon as the start has been taken. A zero divisor raises a flag rather than leaving the remainder undefined.

Top module: `div_unit`

## Requirements
- R1: When `op_i` equals 3'b111 at a rising clock edge while `busy_o` is low, a division starts, and `busy_o` is high after that edge.
- R2: `busy_o` stays high for exactly 33 consecutive clock cycles after an accepted start, and then falls.
- R3: Any opcode other than 3'b111 has no effect. A 3'b111 that arrives while `busy_o` is high is also ignored. In both cases the outputs and the running operation are left untouched.
- R4: Once `busy_o` has fallen, `quot_o` holds the unsigned integer quotient floor(dividend / divisor).
- R5: Once `busy_o` has fallen, `rem_o` holds dividend mod divisor, and it is strictly less than the divisor. This includes divisors above 2^31.
- R6: `result_o[63:32]` equals `rem_o` and `result_o[31:0]` equals `quot_o`.
- R7: Operand inputs are captured at the accepted start. Later changes to `dividend_i` or `divisor_i` do not alter the running result.
- R8: A zero divisor at start sets `dbz_o` after that edge. When the operation completes, `quot_o` is all ones and `rem_o` equals the dividend. A later start with a nonzero divisor clears `dbz_o`.
- R9: After reset, `busy_o`, `dbz_o`, `quot_o`, `rem_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode; 3'b111 requests a division |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| busy_o | output | 1 | High while a division is in progress |
| dbz_o | output | 1 | The last accepted start had a zero divisor |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| result_o | output | 64 | Remainder in the upper half, quotient in the lower half |

## Verification
The assertions assume that results are read only while `busy_o` is low. They also assume that the divisor register is the one captured at the start, and not the live input. The bench follows both assumptions. It reads quotient and remainder only after `busy_o` has fallen, and it deliberately moves the operand inputs and re-issues the start opcode mid-operation to confirm that the loop ignores them. The stimulus is driven on falling edges, so every start is seen cleanly at a single rising edge.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam logic [2:0] OP_DIV = 3'b111;

  function automatic int cnt_width(input int dw);
    return $clog2(dw + 1);
  endfunction
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int DW = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o
);
  localparam int CW = div_pkg::cnt_width(DW);
  localparam logic [CW-1:0] CNT_INIT = CW'(DW);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q && (cnt_q != '0);
  assign busy_o = busy_q;

  // one finishing cycle after the last step gives 33 busy cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_o) begin
      cnt_q  <= CNT_INIT;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (busy_q && cnt_q == CNT_INIT)); // R1
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == '0)); // R2
  AST_LOAD_XOR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, step_o})); // R3
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          dbz_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  localparam int AW = 2 * DW + 1;  // extra top bit keeps large divisors exact
  localparam int HW = DW + 1;

  logic [AW-1:0] acc_q, acc_nxt;
  logic [DW-1:0] dvs_q;
  logic          dbz_q;
  logic [HW-1:0] hi, diff;
  logic [DW-1:0] lo;
  logic          fits;

  assign hi   = acc_q[AW-1:DW];
  assign lo   = acc_q[DW-1:0];
  assign fits = hi >= {1'b0, dvs_q};
  assign diff = hi - {1'b0, dvs_q};

  always_comb begin
    if (fits) acc_nxt = {diff[DW-1:0], lo, 1'b1};
    else      acc_nxt = {hi[DW-1:0], lo, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dvs_q <= '0;
      dbz_q <= 1'b0;
    end else if (load_i) begin
      acc_q <= {{DW{1'b0}}, dividend_i, 1'b0};  // pre-shifted by one
      dvs_q <= divisor_i;
      dbz_q <= (divisor_i == '0);
    end else if (step_i) begin
      acc_q <= acc_nxt;
    end
  end

  assign quot_o = lo;
  assign rem_o  = hi[DW:1];  // undo the load pre-shift
  assign dbz_o  = dbz_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(acc_q)); // R3
  AST_DVS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dvs_q)); // R7
  AST_DIFF_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && fits) |-> !diff[DW]); // R5
  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i && dvs_q != '0) |-> (rem_o < dvs_q)); // R5
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          dbz_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o,
  output logic [2*DW-1:0] result_o
);
  logic start, load, step;

  assign start = (op_i == div_pkg::OP_DIV);

  div_ctrl #(.DW(DW)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy_o),
    .load_o (load),
    .step_o (step)
  );

  div_datapath #(.DW(DW)) i_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .dbz_o     (dbz_o),
    .quot_o    (quot_o),
    .rem_o     (rem_o)
  );

  assign result_o = {rem_o, quot_o};

  AST_DBZ_QUOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && dbz_o) |-> (&quot_o)); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy_o) |=> busy_o); // R1
endmodule

// File: tb/test_div_unit.sv
module test_div_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] dvd = '0, dvs = '0;
  logic        busy, dbz;
  logic [31:0] quot, rem;
  logic [63:0] result;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  div_unit i_div_unit (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .dbz_o(dbz), .quot_o(quot), .rem_o(rem), .result_o(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = 3'b111; dvd = a; dvs = b;
    @(negedge clk);
    op = 3'b000;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_div(input logic [31:0] a, input logic [31:0] b);
    int cyc;
    start_op(a, b);
    chk("R1 busy after start", {63'd0, busy}, 64'd1);
    wait_done(cyc);
    chk("R2 busy length", 64'(cyc), 64'd33);
    if (b != 0) begin
      chk("R4 quotient", {32'd0, quot}, {32'd0, a / b});
      chk("R5 remainder", {32'd0, rem}, {32'd0, a % b});
      chk("R8 dbz clear", {63'd0, dbz}, 64'd0);
    end
    chk("R6 packed", result, {rem, quot});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 busy", {63'd0, busy}, 64'd0);
    chk("R9 dbz", {63'd0, dbz}, 64'd0);
    chk("R9 result", result, 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_basic;
    run_div(32'd10, 32'd2);
    run_div(32'd18, 32'd5);
    run_div(32'd34, 32'd6);
  endtask

  task automatic t_edges;
    run_div(32'd7, 32'd9);              // divisor above dividend
    run_div(32'hFFFF_FFFF, 32'd7);      // all-ones dividend
    run_div(32'hDEAD_BEEF, 32'd1);      // unit divisor
    run_div(32'hFFFF_FFFF, 32'h8000_0001); // R5 divisor above 2^31
    run_div(32'h9000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_zero;
    int cyc;
    start_op(32'd5, 32'd0);
    chk("R8 dbz set", {63'd0, dbz}, 64'd1);
    wait_done(cyc);
    chk("R8 quotient all ones", {32'd0, quot}, 64'h0000_0000_FFFF_FFFF);
    chk("R8 remainder is dividend", {32'd0, rem}, 64'd5);
    run_div(32'd9, 32'd4);  // clears dbz (checked inside as R8)
  endtask

  task automatic t_ignore;
    int cyc;
    logic [63:0] hold;
    start_op(32'd100, 32'd7);
    // R3 / R7: re-start and new operands mid-run are ignored
    dvd = 32'd55; dvs = 32'd3; op = 3'b111;
    @(negedge clk);
    @(negedge clk);
    op = 3'b000;
    wait_done(cyc);
    chk("R3 busy length unchanged", 64'(cyc + 2), 64'd33);
    chk("R7 quotient", {32'd0, quot}, 64'd14);
    chk("R7 remainder", {32'd0, rem}, 64'd2);
    // R3: non-divide opcodes while idle
    hold = result;
    op = 3'b001; @(negedge clk);
    op = 3'b110; @(negedge clk);
    op = 3'b010; @(negedge clk);
    op = 3'b000; @(negedge clk);
    chk("R3 idle busy", {63'd0, busy}, 64'd0);
    chk("R3 idle result", result, hold);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_edges();
    t_zero();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule